// File: doc/BRIEF.md
# Masked Vector Element Compress

This unit accepts a vector of eight 32-bit elements together with an 8-bit keep-mask. It gathers every element whose mask bit is set and places those elements side by side, starting at element position 0, in the same relative order they had in the source. The positions above this packed run are filled by one of two policies. In zeroing mode they are cleared. In merge mode they take the same-numbered elements of a destination vector supplied alongside the source.

The mask is a run-time input, so each request can select a different subset. Every output position is found from a prefix count over the mask: output position p takes the selected element that has exactly p selected elements below it. The result vector, the number of packed elements and a valid strobe are registered, and they appear one clock after the input strobe.

Top module: `vec_pack_unit`

## Requirements
- R1: Element i occupies bits [32*i+31:32*i] of a vector, and mask bit i refers to element i. If the mask has n bits set, output positions 0..n-1 hold the selected source elements in ascending source index order.
- R2: When in_mode is 0 (zeroing), every output position at or above n is zero.
- R3: When in_mode is 1 (merge), every output position p at or above n equals element p of in_dst.
- R4: out_cnt equals the number of set bits in the mask of the accepted request.
- R5: An all-zero mask gives out_cnt 0. The result is the zero vector in zeroing mode and in_dst unchanged in merge mode.
- R6: An all-ones mask returns in_src unchanged in either mode.
- R7: A request presented with in_valid high at a rising clock edge produces its result, with out_valid high, after that edge. out_valid is low after any edge at which in_valid was low.
- R8: While in_valid is low, out_vec and out_cnt keep their last values, whatever the other inputs do.
- R9: While reset is asserted, out_valid, out_vec and out_cnt are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_src | input | 256 | Source vector, eight 32-bit elements |
| in_dst | input | 256 | Destination vector used by merge mode |
| in_mask | input | 8 | Keep-mask, bit i selects element i |
| in_mode | input | 1 | 0 = zeroing fill, 1 = merge fill |
| out_valid | output | 1 | Result strobe |
| out_vec | output | 256 | Packed result vector |
| out_cnt | output | 4 | Number of packed elements |

## Verification
A wrong prefix count for any one mask bit moves an element to the wrong position, or duplicates it. This shows on out_vec in the cycle right after the request. It can also turn a fill position into a data position, and that shows as a disagreement between out_cnt and the boundary where fill begins. Swapping the fill policy or misplacing the boundary only shows on masks with fewer than eight set bits. Directed all-zero, all-ones and single-bit masks in both modes are therefore mixed with random masks. Every output lane is compared in every cycle, so any corruption is caught on the first affected request.

// File: rtl/vec_pack_pkg.sv
package vec_pack_pkg;
    typedef enum logic {
        FILL_ZERO = 1'b0,
        FILL_KEEP = 1'b1
    } fill_mode_e;
endpackage

// File: rtl/vec_pack_rank.sv
module vec_pack_rank #(
    parameter int LANES = 8,
    parameter int CW    = $clog2(LANES + 1)
) (
    input  logic [LANES-1:0]    mask,
    output logic [LANES*CW-1:0] rank,
    output logic [CW-1:0]       total
);
    logic [CW-1:0] run;

    always_comb begin
        run  = '0;
        rank = '0;
        for (int i = 0; i < LANES; i++) begin
            rank[i*CW +: CW] = run;
            run = run + CW'(mask[i]);
        end
        total = run;
    end
endmodule

// File: rtl/vec_pack_select.sv
module vec_pack_select
    import vec_pack_pkg::*;
#(
    parameter int LANES = 8,
    parameter int EW    = 32,
    parameter int CW    = $clog2(LANES + 1)
) (
    input  logic [LANES*EW-1:0] src,
    input  logic [LANES*EW-1:0] dst,
    input  logic [LANES-1:0]    mask,
    input  logic [LANES*CW-1:0] rank,
    input  logic [CW-1:0]       total,
    input  fill_mode_e          mode,
    output logic [LANES*EW-1:0] vec
);
    for (genvar p = 0; p < LANES; p++) begin : g_pos
        logic [EW-1:0] pick;
        logic [EW-1:0] fill;

        always_comb begin
            pick = '0;
            for (int i = 0; i < LANES; i++) begin
                if (mask[i] && (rank[i*CW +: CW] == CW'(p))) begin
                    pick = pick | src[i*EW +: EW];
                end
            end
            fill = (mode == FILL_KEEP) ? dst[p*EW +: EW] : '0;
            vec[p*EW +: EW] = (CW'(p) < total) ? pick : fill;
        end
    end
endmodule

// File: rtl/vec_pack_unit.sv
module vec_pack_unit
    import vec_pack_pkg::*;
#(
    parameter int LANES = 8,
    parameter int EW    = 32,
    localparam int CW   = $clog2(LANES + 1),
    localparam int VW   = LANES * EW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [VW-1:0]    in_src,
    input  logic [VW-1:0]    in_dst,
    input  logic [LANES-1:0] in_mask,
    input  logic             in_mode,
    output logic             out_valid,
    output logic [VW-1:0]    out_vec,
    output logic [CW-1:0]    out_cnt
);
    typedef struct packed {
        logic          vld;
        logic [VW-1:0] vec;
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    logic [LANES*CW-1:0] rank_w;
    logic [CW-1:0]       total_w;
    logic [VW-1:0]       packed_w;
    fill_mode_e          mode_w;

    assign mode_w = fill_mode_e'(in_mode);

    vec_pack_rank #(.LANES(LANES), .CW(CW)) rank_i (
        .mask  (in_mask),
        .rank  (rank_w),
        .total (total_w)
    );

    vec_pack_select #(.LANES(LANES), .EW(EW), .CW(CW)) sel_i (
        .src   (in_src),
        .dst   (in_dst),
        .mask  (in_mask),
        .rank  (rank_w),
        .total (total_w),
        .mode  (mode_w),
        .vec   (packed_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.vec = packed_w;
            st_d.cnt = total_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_vec   = st_q.vec;
    assign out_cnt   = st_q.cnt;

    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R7
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R4
    count_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_cnt == CW'($countones($past(in_mask)))));

    // R6
    all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (&in_mask)) |=> (out_vec == $past(in_src)));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_vec) && $stable(out_cnt)));

    for (genvar p = 0; p < LANES; p++) begin : g_fill_chk
        // R2
        zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !in_mode && ($countones(in_mask) <= p))
            |=> (out_vec[p*EW +: EW] == '0));

        // R3
        merge_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_mode && ($countones(in_mask) <= p))
            |=> (out_vec[p*EW +: EW] == $past(in_dst[p*EW +: EW])));
    end
endmodule

// File: tb/vec_pack_unit_tb_top.sv
module vec_pack_unit_tb_top;
    localparam int LANES = 8;
    localparam int EW    = 32;
    localparam int VW    = LANES * EW;
    localparam int CW    = 4;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             in_valid;
    logic [VW-1:0]    in_src;
    logic [VW-1:0]    in_dst;
    logic [LANES-1:0] in_mask;
    logic             in_mode;
    logic             out_valid;
    logic [VW-1:0]    out_vec;
    logic [CW-1:0]    out_cnt;

    int n_cmp = 0;
    int n_bad = 0;

    logic          exp_vld;
    logic [VW-1:0] exp_vec;
    logic [CW-1:0] exp_cnt;
    logic          exp_mode;

    always #5 clk = ~clk;

    vec_pack_unit #(.LANES(LANES), .EW(EW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_src    (in_src),
        .in_dst    (in_dst),
        .in_mask   (in_mask),
        .in_mode   (in_mode),
        .out_valid (out_valid),
        .out_vec   (out_vec),
        .out_cnt   (out_cnt)
    );

    task automatic cmp(input string req, input logic [EW-1:0] act, input logic [EW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Compare every output against the behavioural expectation.
    task automatic check_all(input string tag);
        cmp({tag, " R7 valid"}, EW'(out_valid), EW'(exp_vld));
        cmp({tag, " R4 count"}, EW'(out_cnt), EW'(exp_cnt));
        for (int p = 0; p < LANES; p++) begin
            if (p < int'(exp_cnt))
                cmp({tag, " R1 packed lane"}, out_vec[p*EW +: EW], exp_vec[p*EW +: EW]);
            else if (exp_mode)
                cmp({tag, " R3 merge lane"}, out_vec[p*EW +: EW], exp_vec[p*EW +: EW]);
            else
                cmp({tag, " R2 zero lane"}, out_vec[p*EW +: EW], exp_vec[p*EW +: EW]);
        end
    endtask

    // Behavioural model built from a queue of kept elements.
    task automatic model(input logic [VW-1:0] s, input logic [VW-1:0] d,
                         input logic [LANES-1:0] m, input logic md);
        logic [EW-1:0] kept[$];
        for (int i = 0; i < LANES; i++)
            if (m[i]) kept.push_back(s[i*EW +: EW]);
        exp_cnt  = CW'(kept.size());
        exp_mode = md;
        for (int p = 0; p < LANES; p++) begin
            if (p < kept.size()) exp_vec[p*EW +: EW] = kept[p];
            else                 exp_vec[p*EW +: EW] = md ? d[p*EW +: EW] : '0;
        end
    endtask

    task automatic send(input string tag, input logic v, input logic [VW-1:0] s,
                        input logic [VW-1:0] d, input logic [LANES-1:0] m, input logic md);
        in_valid = v; in_src = s; in_dst = d; in_mask = m; in_mode = md;
        if (v) model(s, d, m, md);
        exp_vld = v;
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    function automatic logic [VW-1:0] rnd_vec();
        logic [VW-1:0] r;
        for (int i = 0; i < LANES; i++) r[i*EW +: EW] = $urandom;
        return r;
    endfunction

    logic [VW-1:0] ramp_src, ramp_dst;

    initial begin
        for (int i = 0; i < LANES; i++) begin
            ramp_src[i*EW +: EW] = 32'hA000_0000 + i;
            ramp_dst[i*EW +: EW] = 32'hD000_0000 + i;
        end
        rst_n = 1'b0; in_valid = 1'b0; in_src = ramp_src; in_dst = ramp_dst;
        in_mask = '1; in_mode = 1'b0;
        exp_vld = 1'b0; exp_vec = '0; exp_cnt = '0; exp_mode = 1'b0;
        repeat (3) @(negedge clk);
        check_all("R9 reset");
        rst_n = 1'b1;
        @(negedge clk);

        send("R1 mask 5A zero", 1'b1, ramp_src, ramp_dst, 8'h5A, 1'b0);
        send("R3 mask 81 merge", 1'b1, ramp_src, ramp_dst, 8'h81, 1'b1);
        send("R5 empty zero", 1'b1, ramp_src, ramp_dst, 8'h00, 1'b0);
        send("R5 empty merge", 1'b1, ramp_src, ramp_dst, 8'h00, 1'b1);
        send("R6 full zero", 1'b1, ramp_src, ramp_dst, 8'hFF, 1'b0);
        send("R6 full merge", 1'b1, ramp_src, ramp_dst, 8'hFF, 1'b1);
        for (int b = 0; b < LANES; b++) begin
            send("R1 single zero", 1'b1, ramp_src, ramp_dst, 8'(1 << b), 1'b0);
            send("R3 single merge", 1'b1, ramp_src, ramp_dst, 8'(1 << b), 1'b1);
        end
        send("R2 mask 80 zero", 1'b1, ramp_src, ramp_dst, 8'h80, 1'b0);
        send("R1 mask 7F merge", 1'b1, ramp_src, ramp_dst, 8'h7F, 1'b1);

        // R8: idle cycles with changing inputs must leave the result untouched.
        send("R8 idle hold", 1'b0, rnd_vec(), rnd_vec(), 8'h3C, 1'b1);
        send("R8 idle hold", 1'b0, rnd_vec(), rnd_vec(), 8'h00, 1'b0);

        for (int k = 0; k < 400; k++) begin
            logic v;
            v = ($urandom % 4) != 0;
            send("random", v, rnd_vec(), rnd_vec(), 8'($urandom), 1'($urandom));
        end

        // R9: reset in mid-run clears all outputs.
        in_valid = 1'b1; in_mask = 8'hFF;
        rst_n = 1'b0;
        exp_vld = 1'b0; exp_vec = '0; exp_cnt = '0; exp_mode = 1'b0;
        @(negedge clk);
        check_all("R9 reset again");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule